// File: doc/BRIEF.md
# Weighted Vector Histogram Accumulator

This block builds histograms from a stream of elements and keeps the counts in a bank of 16-bit counters. The bank holds 32 count registers. Each register holds `VEC_ELEMS` counters. An element's bin value picks the register and the low bits of the counter. The element's position inside the current input vector picks a group of eight counters. This spreads a histogram over lane groups, so separate lanes never share a counter.

The engine takes one element per cycle on a valid/ready stream and runs in one of four modes. In halfword modes each element carries a bin and an unsigned weight, and the counter grows by that weight with wrapping, with saturation, or under a per-element predicate. In byte mode each element is a single byte value that adds one to its counter. A synchronous clear zeroes every counter. A registered read port returns any counter, addressed by register and counter index.

Top module: `whist_engine`

## Requirements
- R1: In halfword modes, bits 7:0 of `inElem` are the bin and bits 15:8 are an unsigned weight that is added to the selected counter.
- R2: In halfword modes the selected register is bin bits 7:3, which gives one of 32 registers.
- R3: The selected counter is the element position with its three low bits cleared, ORed with bin bits 2:0. The position starts at 0, advances on every accepted element, and wraps to 0 after `VEC_ELEMS-1` in halfword modes.
- R4: In mode 0 (wrap) the counter becomes (counter + weight) modulo 65536.
- R5: In mode 1 (saturate) the counter becomes min(counter + weight, 0xFFFF).
- R6: In mode 2 (masked) the element at position i updates its counter, with wrapping, only when `predVec[2*i]`=1. Masked elements still advance the position.
- R7: In mode 3 (byte), `inElem[7:0]` is a value v and `inElem[15:8]` is ignored. The register is v>>3. The counter is ((position>>1) with its three low bits cleared) OR v[2:0], and it grows by 1. The position wraps after 2*`VEC_ELEMS`-1.
- R8: When elements hit the same counter in back-to-back cycles, every one of them adds to the count.
- R9: While `clr`=1, `inReady`=0. One clear cycle zeroes all counters and returns the position to 0.
- R10: `rdData` shows the counter addressed by `rdReg`/`rdElem` at the previous clock edge. An element accepted at edge k shows up in a read whose address is sampled at edge k+2 or later.
- R11: After reset every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters and of the position |
| mode | input | 2 | 0 wrap, 1 saturate, 2 masked, 3 byte |
| predVec | input | 2*VEC_ELEMS | Predicate vector; bit 2*i enables element i in masked mode |
| inValid | input | 1 | Element valid |
| inReady | output | 1 | Element accepted when high together with inValid |
| inElem | input | 16 | Element: weight in bits 15:8, bin in bits 7:0 |
| rdReg | input | 5 | Read register index |
| rdElem | input | $clog2(VEC_ELEMS) | Read counter index |
| rdData | output | 16 | Registered counter value |

## Verification
The bench streams vectors in every mode and compares the full counter bank against a bench-side model. It aims at the places where a faulty design would go wrong:
- **Long runs into one counter.** These push past 65535. A design that wrapped in saturate mode, or clamped in wrap mode, would show the wrong final value.
- **Back-to-back hits on one counter.** These expose a stale read-modify-write, which would drop all but the last weight.
- **Position wrap.** The 17th element must land in group 0, so a position counter that does not wrap or wraps late is caught.
- **Predicates set only on odd bits.** These catch a design that reads the wrong predicate bit.
- **Upper byte in byte mode.** It carries junk, so a design that used it as a weight would show counts other than one.

// File: rtl/whist_pkg.sv
package whist_pkg;
  localparam int NUM_REGS  = 32;
  localparam int REG_IDX_W = 5;
  localparam int CNT_W     = 16;

  typedef enum logic [1:0] {
    MODE_WRAP = 2'd0,
    MODE_SAT  = 2'd1,
    MODE_MASK = 2'd2,
    MODE_BYTE = 2'd3
  } histMode_t;

  // Strobes from control to datapath: one pending counter update
  typedef struct packed {
    logic                 upd;
    logic                 sat;
    logic [REG_IDX_W-1:0] regIdx;
    logic [7:0]           cntIdx;
    logic [7:0]           weight;
  } histStrobe_t;
endpackage

// File: rtl/whist_ctrl.sv
module whist_ctrl
  import whist_pkg::*;
#(
  parameter int VEC_ELEMS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clr,
  input  logic [1:0]             mode,
  input  logic [2*VEC_ELEMS-1:0] predVec,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [15:0]            inElem,
  output histStrobe_t            stb
);
  localparam int POS_W = $clog2(2 * VEC_ELEMS);

  histMode_t              curMode;
  logic [POS_W-1:0]       posCnt;
  logic [POS_W-1:0]       lastPos;
  logic [POS_W-1:0]       grpPos;
  logic [POS_W-1:0]       cntFull;
  logic [2*VEC_ELEMS-1:0] predShift;
  logic                   accept;
  logic                   isByte;
  logic                   predOk;
  logic                   doUpd;

  assign inReady = !clr;

  always_comb begin
    curMode   = histMode_t'(mode);
    accept    = inValid && inReady;
    isByte    = (curMode == MODE_BYTE);
    lastPos   = isByte ? POS_W'(2 * VEC_ELEMS - 1) : POS_W'(VEC_ELEMS - 1);
    grpPos    = isByte ? (posCnt >> 1) : posCnt;
    cntFull   = (grpPos & ~POS_W'(7)) | POS_W'(inElem[2:0]);
    predShift = predVec >> {posCnt, 1'b0};
    predOk    = (curMode != MODE_MASK) || predShift[0];
    doUpd     = accept && predOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt <= '0;
      stb    <= '0;
    end else if (clr) begin
      posCnt <= '0;
      stb    <= '0;
    end else begin
      stb.upd    <= doUpd;
      stb.sat    <= (curMode == MODE_SAT);
      stb.regIdx <= inElem[7:3];
      stb.cntIdx <= 8'(cntFull);
      stb.weight <= isByte ? 8'd1 : inElem[15:8];
      if (accept) posCnt <= (posCnt >= lastPos) ? '0 : posCnt + 1'b1;
    end
  end

  // R9: a clear returns the element position to zero
  assert_clear_pos_R9: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (posCnt == '0));

  // R6: an element whose predicate bit is low issues no update
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && curMode == MODE_MASK && !predShift[0]) |=> !stb.upd);
endmodule

// File: rtl/whist_dp.sv
module whist_dp
  import whist_pkg::*;
#(
  parameter int VEC_ELEMS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  histStrobe_t                  stb,
  input  logic [REG_IDX_W-1:0]         rdReg,
  input  logic [$clog2(VEC_ELEMS)-1:0] rdElem,
  output logic [CNT_W-1:0]             rdData
);
  localparam int CIW = $clog2(VEC_ELEMS);

  logic [CNT_W-1:0] bank [NUM_REGS][VEC_ELEMS];
  logic [CIW-1:0]   cntI;
  logic [CNT_W-1:0] cur;
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    cntI    = stb.cntIdx[CIW-1:0];
    cur     = bank[stb.regIdx][cntI];
    sumWide = {1'b0, cur} + (CNT_W + 1)'(stb.weight);
    nxt     = (stb.sat && sumWide[CNT_W]) ? {CNT_W{1'b1}} : sumWide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int c = 0; c < VEC_ELEMS; c++) bank[r][c] <= '0;
      rdData <= '0;
    end else begin
      if (clr) begin
        for (int r = 0; r < NUM_REGS; r++)
          for (int c = 0; c < VEC_ELEMS; c++) bank[r][c] <= '0;
      end else if (stb.upd) begin
        bank[stb.regIdx][cntI] <= nxt;
      end
      rdData <= bank[rdReg][rdElem];
    end
  end

  // R5: a saturating update never lowers the counter
  assert_sat_monotone_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.upd && stb.sat && !clr) |=> (bank[$past(stb.regIdx)][$past(cntI)] >= $past(cur)));

  // R4: a wrapping update lands on old value plus weight modulo 2^16
  assert_wrap_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.upd && !stb.sat && !clr) |=>
      (bank[$past(stb.regIdx)][$past(cntI)] == CNT_W'($past(cur) + CNT_W'($past(stb.weight)))));

  // R9: two cycles after a clear the read port returns zero
  assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    clr |-> ##2 (rdData == '0));
endmodule

// File: rtl/whist_engine.sv
module whist_engine
  import whist_pkg::*;
#(
  parameter int VEC_ELEMS = 16  // multiple of 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  logic [1:0]                   mode,
  input  logic [2*VEC_ELEMS-1:0]       predVec,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [15:0]                  inElem,
  input  logic [4:0]                   rdReg,
  input  logic [$clog2(VEC_ELEMS)-1:0] rdElem,
  output logic [15:0]                  rdData
);
  histStrobe_t stb;

  whist_ctrl #(.VEC_ELEMS(VEC_ELEMS)) u_ctrl (
    .clk(clk), .rstN(rstN), .clr(clr), .mode(mode), .predVec(predVec),
    .inValid(inValid), .inReady(inReady), .inElem(inElem), .stb(stb)
  );

  whist_dp #(.VEC_ELEMS(VEC_ELEMS)) u_dp (
    .clk(clk), .rstN(rstN), .clr(clr), .stb(stb),
    .rdReg(rdReg), .rdElem(rdElem), .rdData(rdData)
  );
endmodule

// File: tb/whist_engine_tb.sv
module whist_engine_tb;
  localparam int  N      = 16;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clr = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [2*N-1:0] predVec = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [15:0]   inElem = '0;
  logic [4:0]    rdReg = '0;
  logic [3:0]    rdElem = '0;
  logic [15:0]   rdData;

  int model [32][N];
  int pos = 0;
  int nChecks = 0;
  int nFails = 0;

  always #(PERIOD / 2) clk = ~clk;

  whist_engine #(.VEC_ELEMS(N)) u_dut (
    .clk(clk), .rstN(rstN), .clr(clr), .mode(mode), .predVec(predVec),
    .inValid(inValid), .inReady(inReady), .inElem(inElem),
    .rdReg(rdReg), .rdElem(rdElem), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of one accepted element, written from the requirements
  task automatic modelElem(input logic [15:0] e);
    int r, c, w, lim, s;
    bit en;
    if (mode == 2'd3) begin
      r = e[7:3]; c = ((pos >> 1) & ~7) | e[2:0]; w = 1; lim = 2 * N; en = 1;
    end else begin
      r = e[7:3]; c = (pos & ~7) | e[2:0]; w = e[15:8]; lim = N;
      en = (mode != 2'd2) || predVec[2*pos];
    end
    if (en) begin
      s = model[r][c] + w;
      if (mode == 2'd1 && s > 65535) s = 65535;
      model[r][c] = s & 16'hFFFF;
    end
    pos = (pos >= lim - 1) ? 0 : pos + 1;
  endtask

  task automatic send(input logic [15:0] e);
    inValid = 1'b1; inElem = e;
    @(negedge clk);
    modelElem(e);
  endtask

  task automatic idle();
    inValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic readOne(input int r, input int c, output int v);
    rdReg = 5'(r); rdElem = 4'(c);
    @(negedge clk);
    v = rdData;
  endtask

  task automatic sweep(input string req);
    int bad = 0, fa = 0, fe = 0, v;
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < N; c++) begin
        readOne(r, c, v);
        if (v != model[r][c]) begin
          if (bad == 0) begin fa = v; fe = model[r][c]; end
          bad++;
        end
      end
    chk(bad == 0, req, fa, fe);
  endtask

  task automatic point(input int r, input int c, input int exp, input string req);
    int v;
    readOne(r, c, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic doClear();
    clr = 1'b1;
    #1 chk(inReady == 1'b0, "R9 ready low in clear", inReady, 0);
    @(negedge clk);
    clr = 1'b0;
    for (int r = 0; r < 32; r++) for (int c = 0; c < N; c++) model[r][c] = 0;
    pos = 0;
  endtask

  task automatic tReset();
    sweep("R11 reset zero");
  endtask

  task automatic tWrapBasic();
    doClear(); mode = 2'd0;
    send(16'h102B); // weight 0x10, bin 0x2B -> reg 5, counter 3
    for (int i = 1; i < N; i++) send(16'(((i + 1) << 8) | ((i * 37 + 3) & 8'hFF)));
    send(16'h0709); // position wrapped: group 0, reg 1, counter 1
    idle();
    point(5, 3, 16, "R1 R2 weight into reg bin[7:3]");
    point(1, 1, model[1][1], "R3 position wraps to group 0");
    sweep("R1 R3 wrap-mode bank");
  endtask

  task automatic tBackToBack();
    doClear(); mode = 2'd0;
    for (int i = 0; i < 8; i++) send(16'(((i + 3) << 8) | 8'h42));
    idle();
    point(8, 2, 3+4+5+6+7+8+9+10, "R8 back-to-back same counter");
  endtask

  task automatic tOverflow(input logic [1:0] m, input int exp, input string req);
    doClear(); mode = m;
    for (int i = 0; i < 33 * N; i++) send(16'hFF00);
    send(16'h0100); // position 0 again after whole vectors
    idle();
    point(0, 0, exp, req);
    sweep(req);
  endtask

  task automatic tMask();
    doClear(); mode = 2'd2;
    predVec = 32'hAAAA_AAA1; // only element 0 enabled (odd bits set)
    for (int i = 0; i < N; i++) send(16'(16'h0500 | ((i & 7) << 3) | (i & 7)));
    idle();
    point(0, 0, 5, "R6 predicate bit 0 enables element 0");
    point(1, 1, 0, "R6 odd predicate bit does not enable");
    sweep("R6 single-enable bank");
    predVec = 32'h1144_4411;
    for (int i = 0; i < 2 * N; i++) send(16'(((i + 1) << 8) | (i * 29 & 8'hFF)));
    idle();
    sweep("R6 mixed predicates");
  endtask

  task automatic tByte();
    doClear(); mode = 2'd3;
    for (int i = 0; i < 2 * N; i++) begin
      if (i == 20) send(16'hA53E);
      else send(16'(16'hA500 | ((i * 53 + 7) & 8'hFF)));
    end
    idle();
    point(7, 14, model[7][14], "R7 byte position 20 -> counter 14");
    chk(model[7][14] >= 1, "R7 model sanity", model[7][14], 1);
    sweep("R7 byte bank");
  endtask

  task automatic tClear();
    mode = 2'd0;
    send(16'h0333); send(16'h0333); send(16'h0333); // pos now 3
    doClear();
    idle();
    sweep("R9 clear zeroes bank");
    send(16'h0401); // must land in group 0 at counter 1
    idle();
    point(0, 1, 4, "R9 clear resets position");
  endtask

  task automatic tLatency();
    int v;
    doClear(); mode = 2'd0;
    rdReg = 5'd2; rdElem = 4'd4;
    inValid = 1'b1; inElem = 16'h0914; // reg 2, counter 4, weight 9
    @(negedge clk);           // accepted at edge k
    modelElem(16'h0914);
    inValid = 1'b0;
    @(negedge clk);           // rdData sampled at k+1
    v = rdData;
    chk(v == 0, "R10 not visible at k+1", v, 0);
    @(negedge clk);           // sampled at k+2
    v = rdData;
    chk(v == 9, "R10 visible at k+2", v, 9);
  endtask

  initial begin
    #(PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) for (int c = 0; c < N; c++) model[r][c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrapBasic();
    tBackToBack();
    tOverflow(2'd0, (33 * 8 * 255 + 1) % 65536, "R4 wrap past 0xFFFF");
    tOverflow(2'd1, 65535, "R5 saturate at 0xFFFF");
    tMask();
    tByte();
    tClear();
    tLatency();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule